// File: doc/BRIEF.md
# CAN Controller Mode and Reset Sequencer

This block supervises the operating mode of a CAN protocol controller. It holds the control and status bits that software sees: module disable, halt, freeze enable, the soft-reset request with its pending state, the clock-source select, freeze acknowledge and not-ready. It moves the controller through six modes: disabled, freeze, synchronizing, normal, freeze-pending and low-power. It also decides when configuration writes land. The bit engine, message storage, acceptance filtering and interrupts sit outside. The block talks to them only through an engine enable, a transmit force-recessive output, a bus-synchronized input and an engine-idle input.

A soft reset comes from a control-write bit or from an external pulse. It is carried into the protocol clock domain as a four-phase request/acknowledge. The acknowledge is synchronized back, so the pending bit stays visible until the far side confirms. Leaving disable always lands in freeze. Freeze is the only mode in which the protocol configuration word can be written. The clock-source select can be written only while disabled. Message storage is outside the block, so no reset source clears it.

Top module: `can_mode_seq`

## Requirements
- R1: After hard reset (rst_n low, asynchronous): st_mode=0 (disabled), st_dis=1, st_halt=1, st_frz_en=1, st_frz_ack=0, st_not_rdy=1, tx_force_rec=1, eng_en=0, st_clksel=0, cfg_q=0, st_srst_pend=0.
- R2: A control write with ctl_dis=0 while disabled moves the block to freeze (st_mode=1) at the next edge. This holds whatever halt value is written. In freeze, st_halt, st_frz_en, st_frz_ack and st_not_rdy all read 1.
- R3: In freeze, tx_force_rec=1 and eng_en=0.
- R4: A control write updates st_clksel only while st_mode=0. In any other mode the field keeps its value.
- R5: A cfg_wr updates cfg_q only while st_mode=1. In other modes the write is ignored.
- R6: A control write with ctl_halt=0 in freeze moves the block to synchronizing (st_mode=2). There st_frz_ack=0, st_not_rdy=1, eng_en=1 and tx_force_rec=1. One edge after bus_synced is seen high, st_mode=3 (normal), st_not_rdy=0 and tx_force_rec=0.
- R7: In normal mode, a control write with ctl_halt=1 and ctl_frz_en=1 moves the block to freeze-pending (st_mode=4, st_frz_ack=0). It enters freeze one edge after eng_idle is seen high. The same write with ctl_frz_en=0 leaves the block in normal mode.
- R8: A soft-reset request sets st_srst_pend and core_srst_req at the next edge. Both stay 1 until the acknowledge has passed through SYNC_STAGES flops. They clear one edge later.
- R9: When a soft reset completes, halt and freeze enable read 1 and cfg_q reads 0. A block that is not disabled enters freeze. The disable state and st_clksel are preserved.
- R10: A one-cycle ext_srst pulse starts the same handshake and has the same effect as the register request.
- R11: lp_req high moves the block to low power (st_mode=5, st_not_rdy=1, tx_force_rec=1, eng_en=0). While in low power, soft-reset requests are refused (st_srst_pend stays 0). Dropping lp_req returns the block to freeze.
- R12: A control write with ctl_dis=1 puts the block in disabled mode at the next edge, from any mode.
- R13: A soft-reset request is refused while the synchronized acknowledge is still high from the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| ext_srst | input | 1 | External soft-reset request pulse |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_dis | input | 1 | Written module-disable value |
| ctl_halt | input | 1 | Written halt value |
| ctl_frz_en | input | 1 | Written freeze-enable value |
| ctl_srst | input | 1 | Written soft-reset request (1 requests) |
| ctl_clksel | input | CLK_W | Written clock-source select |
| cfg_wr | input | 1 | Configuration-word write strobe |
| cfg_wdata | input | CFG_W | Configuration word (bit timing, prescaler, arbitration) |
| lp_req | input | 1 | Low-power request, clocks to stop |
| core_srst_ack | input | 1 | Soft-reset acknowledge from the protocol clock domain |
| bus_synced | input | 1 | Bit engine reports bus synchronization |
| eng_idle | input | 1 | Bit engine idle or at end of frame |
| st_dis | output | 1 | Module-disable status |
| st_halt | output | 1 | Halt status |
| st_frz_en | output | 1 | Freeze-enable status |
| st_srst_pend | output | 1 | Soft reset pending |
| st_clksel | output | CLK_W | Clock-source select |
| st_frz_ack | output | 1 | Freeze acknowledge |
| st_not_rdy | output | 1 | Not ready |
| st_mode | output | 3 | Mode: 0 disabled, 1 freeze, 2 sync, 3 normal, 4 freeze-pending, 5 low power |
| cfg_q | output | CFG_W | Configuration word |
| core_srst_req | output | 1 | Soft-reset request to the protocol clock domain |
| eng_en | output | 1 | Bit engine enable |
| tx_force_rec | output | 1 | Force transmit pin recessive |

## Verification
Every mode change and status change registers once, so it is due one edge after the stimulus. The bench drives inputs on the falling edge and samples at the next falling edge, after exactly one rising edge. The soft-reset pending bit clears SYNC_STAGES+1 edges after the acknowledge rises. The bench checks that it still reads 1 after SYNC_STAGES edges and reads 0 after one more. Before a new request, the bench waits SYNC_STAGES+1 edges so that the acknowledge has dropped through the synchronizer.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [2:0] {
      M_DIS   = 3'd0,
      M_FRZ   = 3'd1,
      M_SYNC  = 3'd2,
      M_NORM  = 3'd3,
      M_FPEND = 3'd4,
      M_LP    = 3'd5
   } mode_e;
endpackage

// File: rtl/cms_sync.sv
module cms_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/cms_srst_hs.sv
module cms_srst_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic req_reg,
   input  logic req_ext,
   input  logic block,
   input  logic ack_s,
   output logic pend,
   output logic accept,
   output logic done
);
   logic pend_q;

   assign accept = (req_reg | req_ext) & ~pend_q & ~block & ~ack_s;
   assign done   = pend_q & ack_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      pend_q <= 1'b0;
      else if (done)   pend_q <= 1'b0;
      else if (accept) pend_q <= 1'b1;

   assign pend = pend_q;
endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
   import can_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ctl_wr,
   input  logic  ctl_dis,
   input  logic  ctl_halt,
   input  logic  ctl_frz_en,
   input  logic  srst_done,
   input  logic  srst_busy,
   input  logic  lp_req,
   input  logic  bus_synced,
   input  logic  eng_idle,
   output mode_e mode,
   output logic  halt,
   output logic  frz_en
);
   mode_e mode_q, mode_d;
   logic  halt_q, halt_d, frz_q, frz_d;
   logic  frz_wr, lp_go;

   assign frz_wr = ctl_wr & ctl_halt & ctl_frz_en;
   assign lp_go  = lp_req & ~srst_busy;

   always_comb begin
      mode_d = mode_q;
      if (ctl_wr && ctl_dis) begin
         mode_d = M_DIS;
      end else if (srst_done) begin
         mode_d = (mode_q == M_DIS) ? M_DIS : M_FRZ;
      end else begin
         unique case (mode_q)
            M_DIS:   if (ctl_wr) mode_d = M_FRZ;
            M_FRZ:   if (lp_go) mode_d = M_LP;
                     else if (ctl_wr && !ctl_halt) mode_d = M_SYNC;
            M_SYNC:  if (lp_go) mode_d = M_LP;
                     else if (frz_wr) mode_d = M_FRZ;
                     else if (bus_synced) mode_d = M_NORM;
            M_NORM:  if (lp_go) mode_d = M_LP;
                     else if (frz_wr) mode_d = M_FPEND;
            M_FPEND: if (eng_idle) mode_d = M_FRZ;
            M_LP:    if (!lp_req) mode_d = M_FRZ;
            default: mode_d = M_DIS;
         endcase
      end
   end

   always_comb begin
      halt_d = halt_q;
      frz_d  = frz_q;
      if (mode_d == M_DIS || mode_d == M_FRZ) begin
         halt_d = 1'b1;
         frz_d  = 1'b1;
      end else if (ctl_wr) begin
         halt_d = ctl_halt;
         frz_d  = ctl_frz_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mode_q <= M_DIS;
         halt_q <= 1'b1;
         frz_q  <= 1'b1;
      end else begin
         mode_q <= mode_d;
         halt_q <= halt_d;
         frz_q  <= frz_d;
      end

   assign mode   = mode_q;
   assign halt   = halt_q;
   assign frz_en = frz_q;
endmodule

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs
   import can_mode_pkg::*;
#(
   parameter int                CLK_W   = 2,
   parameter int                CFG_W   = 16,
   parameter logic [CLK_W-1:0]  CLK_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_e            mode,
   input  logic             ctl_wr,
   input  logic [CLK_W-1:0] ctl_clksel,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             srst_done,
   output logic [CLK_W-1:0] clksel,
   output logic [CFG_W-1:0] cfg
);
   logic [CLK_W-1:0] clk_q;
   logic [CFG_W-1:0] cfg_r;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        clk_q <= CLK_RST;
      else if (ctl_wr && mode == M_DIS)  clk_q <= ctl_clksel;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        cfg_r <= '0;
      else if (srst_done)                cfg_r <= '0;
      else if (cfg_wr && mode == M_FRZ)  cfg_r <= cfg_wdata;

   assign clksel = clk_q;
   assign cfg    = cfg_r;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int                CLK_W       = 2,
   parameter int                CFG_W       = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [CLK_W-1:0]  CLK_RST     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_srst,
   input  logic             ctl_wr,
   input  logic             ctl_dis,
   input  logic             ctl_halt,
   input  logic             ctl_frz_en,
   input  logic             ctl_srst,
   input  logic [CLK_W-1:0] ctl_clksel,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             lp_req,
   input  logic             core_srst_ack,
   input  logic             bus_synced,
   input  logic             eng_idle,
   output logic             st_dis,
   output logic             st_halt,
   output logic             st_frz_en,
   output logic             st_srst_pend,
   output logic [CLK_W-1:0] st_clksel,
   output logic             st_frz_ack,
   output logic             st_not_rdy,
   output logic [2:0]       st_mode,
   output logic [CFG_W-1:0] cfg_q,
   output logic             core_srst_req,
   output logic             eng_en,
   output logic             tx_force_rec
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CLK_W < 1 || CFG_W < 1) begin : g_bad_width
      $error("CLK_W and CFG_W must be positive");
   end

   mode_e mode;
   logic  ack_s, pend, accept, done, halt, frz_en;

   cms_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(core_srst_ack), .q(ack_s)
   );

   cms_srst_hs u_hs (
      .clk(clk), .rst_n(rst_n),
      .req_reg(ctl_wr & ctl_srst), .req_ext(ext_srst),
      .block(mode == M_LP), .ack_s(ack_s),
      .pend(pend), .accept(accept), .done(done)
   );

   cms_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_dis(ctl_dis), .ctl_halt(ctl_halt),
      .ctl_frz_en(ctl_frz_en), .srst_done(done),
      .srst_busy(pend | accept), .lp_req(lp_req),
      .bus_synced(bus_synced), .eng_idle(eng_idle),
      .mode(mode), .halt(halt), .frz_en(frz_en)
   );

   cms_cfg_regs #(.CLK_W(CLK_W), .CFG_W(CFG_W), .CLK_RST(CLK_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .ctl_wr(ctl_wr), .ctl_clksel(ctl_clksel),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .srst_done(done),
      .clksel(st_clksel), .cfg(cfg_q)
   );

   assign st_mode       = mode;
   assign st_dis        = (mode == M_DIS);
   assign st_halt       = halt;
   assign st_frz_en     = frz_en;
   assign st_srst_pend  = pend;
   assign core_srst_req = pend;
   assign st_frz_ack    = (mode == M_FRZ);
   assign st_not_rdy    = !(mode == M_NORM || mode == M_FPEND);
   assign eng_en        = (mode == M_SYNC || mode == M_NORM || mode == M_FPEND);
   assign tx_force_rec  = !(mode == M_NORM || mode == M_FPEND);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
   parameter int CLK_W = 2,
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_dis,
   input logic [2:0]       st_mode,
   input logic             st_halt,
   input logic             st_frz_en,
   input logic             st_frz_ack,
   input logic             st_not_rdy,
   input logic             tx_force_rec,
   input logic             eng_en,
   input logic [CLK_W-1:0] st_clksel,
   input logic [CFG_W-1:0] cfg_q,
   input logic             st_srst_pend,
   input logic             core_srst_ack,
   input logic             bus_synced,
   input logic             eng_idle
);
   p_frz_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode == 3'd1) |-> (st_halt && st_frz_en && st_frz_ack && st_not_rdy
                             && tx_force_rec && !eng_en));

   p_dis_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_mode) == 3'd0 && st_mode != 3'd0) |-> (st_mode == 3'd1));

   p_clksel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode != 3'd0) |=> $stable(st_clksel));

   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode != 3'd1 && !st_srst_pend) |=> $stable(cfg_q));

   p_norm_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode == 3'd3 && $past(st_mode) != 3'd3)
         |-> ($past(st_mode) == 3'd2 && $past(bus_synced)));

   p_frz_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode == 3'd1 && $past(st_mode) == 3'd4) |-> $past(eng_idle));

   p_pend_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_srst_pend) |-> $past(core_srst_ack));

   p_lp_refuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_mode == 3'd5) |=> !st_srst_pend);

   p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_dis) |=> (st_mode == 3'd0));
endmodule

bind can_mode_seq can_mode_seq_chk #(.CLK_W(CLK_W), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_dis(ctl_dis),
   .st_mode(st_mode), .st_halt(st_halt), .st_frz_en(st_frz_en),
   .st_frz_ack(st_frz_ack), .st_not_rdy(st_not_rdy),
   .tx_force_rec(tx_force_rec), .eng_en(eng_en), .st_clksel(st_clksel),
   .cfg_q(cfg_q), .st_srst_pend(st_srst_pend),
   .core_srst_ack(core_srst_ack), .bus_synced(bus_synced),
   .eng_idle(eng_idle)
);

// File: tb/can_mode_seq_tb_top.sv
module can_mode_seq_tb_top;
   localparam int CLK_W = 2;
   localparam int CFG_W = 16;
   localparam int SS    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_srst = 0, ctl_wr = 0, ctl_dis = 0, ctl_halt = 0, ctl_frz_en = 0, ctl_srst = 0;
   logic [CLK_W-1:0] ctl_clksel = '0;
   logic cfg_wr = 0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic lp_req = 0, core_srst_ack = 0, bus_synced = 0, eng_idle = 0;
   logic st_dis, st_halt, st_frz_en, st_srst_pend, st_frz_ack, st_not_rdy;
   logic [CLK_W-1:0] st_clksel;
   logic [2:0] st_mode;
   logic [CFG_W-1:0] cfg_q;
   logic core_srst_req, eng_en, tx_force_rec;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   can_mode_seq #(.CLK_W(CLK_W), .CFG_W(CFG_W), .SYNC_STAGES(SS)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_srst(ext_srst), .ctl_wr(ctl_wr),
      .ctl_dis(ctl_dis), .ctl_halt(ctl_halt), .ctl_frz_en(ctl_frz_en),
      .ctl_srst(ctl_srst), .ctl_clksel(ctl_clksel), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .lp_req(lp_req), .core_srst_ack(core_srst_ack),
      .bus_synced(bus_synced), .eng_idle(eng_idle), .st_dis(st_dis),
      .st_halt(st_halt), .st_frz_en(st_frz_en), .st_srst_pend(st_srst_pend),
      .st_clksel(st_clksel), .st_frz_ack(st_frz_ack), .st_not_rdy(st_not_rdy),
      .st_mode(st_mode), .cfg_q(cfg_q), .core_srst_req(core_srst_req),
      .eng_en(eng_en), .tx_force_rec(tx_force_rec)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic dis, input logic halt, input logic frz,
                         input logic srst, input logic [CLK_W-1:0] cs);
      ctl_wr = 1; ctl_dis = dis; ctl_halt = halt; ctl_frz_en = frz;
      ctl_srst = srst; ctl_clksel = cs;
      tick(1);
      ctl_wr = 0; ctl_srst = 0;
   endtask

   task automatic wr_cfg(input logic [CFG_W-1:0] v);
      cfg_wr = 1; cfg_wdata = v;
      tick(1);
      cfg_wr = 0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset values
      check("R1 mode", st_mode, 0);
      check("R1 dis/halt/frz_en", {st_dis, st_halt, st_frz_en}, 3'b111);
      check("R1 ack/nrdy/tx/eng", {st_frz_ack, st_not_rdy, tx_force_rec, eng_en}, 4'b0110);
      check("R1 clksel/cfg/pend", {st_clksel, cfg_q, st_srst_pend}, 0);

      // R4 sweep clksel while disabled
      for (int v = 0; v < 4; v++) begin
         wr_ctl(1, 1, 1, 0, v[CLK_W-1:0]);
         check("R4 clksel in disabled", st_clksel, v);
      end
      // R5 cfg ignored while disabled
      wr_cfg(16'hABCD);
      check("R5 cfg ignored disabled", cfg_q, 0);

      // R2 leave disable with halt written 0
      wr_ctl(0, 0, 0, 0, 2'd3);
      check("R2 mode freeze", st_mode, 1);
      check("R2 halt/frz/ack/nrdy", {st_halt, st_frz_en, st_frz_ack, st_not_rdy}, 4'hF);
      check("R3 tx/eng in freeze", {tx_force_rec, eng_en}, 2'b10);
      // R4 clksel ignored in freeze
      wr_ctl(0, 1, 1, 0, 2'd1);
      check("R4 clksel ignored freeze", st_clksel, 3);
      check("R2 still freeze", st_mode, 1);
      // R5 cfg sweep in freeze
      for (int k = 0; k < 8; k++) begin
         wr_cfg(CFG_W'(16'h1111 * k + 7));
         check("R5 cfg written freeze", cfg_q, 16'h1111 * k + 7);
      end

      // R6 sync then normal
      wr_ctl(0, 0, 1, 0, 0);
      check("R6 mode sync", st_mode, 2);
      check("R6 sync status", {st_frz_ack, st_not_rdy, eng_en, tx_force_rec}, 4'b0111);
      tick(3);
      check("R6 waits for bus", st_mode, 2);
      bus_synced = 1;
      tick(1);
      check("R6 mode normal", st_mode, 3);
      check("R6 normal status", {st_not_rdy, tx_force_rec, st_frz_ack}, 3'b000);
      wr_cfg(16'h5555);
      check("R5 cfg ignored normal", cfg_q, 16'h7777 + 7);
      wr_ctl(0, 0, 1, 0, 2'd0);
      check("R4 clksel ignored normal", st_clksel, 3);

      // R7 freeze request
      wr_ctl(0, 1, 0, 0, 0);
      check("R7 halt without frz_en stays normal", st_mode, 3);
      wr_ctl(0, 1, 1, 0, 0);
      check("R7 freeze pending", st_mode, 4);
      check("R7 no ack yet", st_frz_ack, 0);
      tick(3);
      check("R7 still pending", st_mode, 4);
      eng_idle = 1;
      tick(1);
      eng_idle = 0;
      check("R7 freeze after idle", {st_mode, st_frz_ack}, {3'd1, 1'b1});

      // R8/R9 soft reset from sync with nonzero cfg
      wr_cfg(16'h3C3C);
      bus_synced = 0;
      wr_ctl(0, 0, 1, 0, 0);
      check("R9 pre sync", st_mode, 2);
      wr_ctl(0, 0, 1, 1, 0);
      check("R8 pending set", {st_srst_pend, core_srst_req}, 2'b11);
      tick(4);
      check("R8 pending held", st_srst_pend, 1);
      core_srst_ack = 1;
      tick(SS);
      check("R8 pending before sync done", st_srst_pend, 1);
      tick(1);
      check("R8 pending cleared", {st_srst_pend, core_srst_req}, 2'b00);
      check("R9 mode freeze", st_mode, 1);
      check("R9 halt/frz/cfg", {st_halt, st_frz_en, cfg_q}, {2'b11, 16'h0});
      check("R9 dis/clksel kept", {st_dis, st_clksel}, {1'b0, 2'd3});
      // R13 refused while ack still high
      wr_ctl(0, 1, 1, 1, 0);
      check("R13 refused while ack high", st_srst_pend, 0);
      core_srst_ack = 0;
      tick(SS + 1);

      // R10 external soft reset
      wr_cfg(16'h0F0F);
      ext_srst = 1;
      tick(1);
      ext_srst = 0;
      check("R10 ext pending", st_srst_pend, 1);
      core_srst_ack = 1;
      tick(SS + 1);
      check("R10 ext completes", {st_srst_pend, cfg_q, st_mode}, {1'b0, 16'h0, 3'd1});
      core_srst_ack = 0;
      tick(SS + 1);

      // R11 low power
      lp_req = 1;
      tick(1);
      check("R11 mode lp", st_mode, 5);
      check("R11 lp status", {st_not_rdy, tx_force_rec, eng_en}, 3'b110);
      wr_ctl(0, 1, 1, 1, 0);
      check("R11 reg srst refused", st_srst_pend, 0);
      ext_srst = 1;
      tick(1);
      ext_srst = 0;
      check("R11 ext srst refused", st_srst_pend, 0);
      lp_req = 0;
      tick(1);
      check("R11 back to freeze", st_mode, 1);

      // R12 disable from normal
      bus_synced = 1;
      wr_ctl(0, 0, 1, 0, 0);
      tick(1);
      check("R12 reached normal", st_mode, 3);
      wr_ctl(1, 0, 0, 0, 0);
      check("R12 disabled", {st_mode, st_dis, tx_force_rec}, {3'd0, 1'b1, 1'b1});

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule